// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every data beat of a synchronous DRAM read or write burst. A start pulse supplies a 9-bit start column, a burst-length code and an ordering bit. From the cycle after that pulse, the block presents one column per beat. It moves to the next beat only when the data path raises the advance input. The column follows one of two orderings. Sequential ordering counts upward and wraps inside the block of columns aligned to the burst length. Interleaved ordering XORs the beat index into the low bits of the start column. A full-page burst counts through all 512 columns of the page and keeps wrapping until a stop or a new start ends it.

The surrounding controller can end a burst on any cycle with the stop input. It can also replace the burst on any cycle with a new start. The block refuses a start whose configuration is illegal, and it reports that configuration on a combinational flag. A fixed-length burst raises the done flag while its final column is shown. The active flag drops after that beat is advanced.

Top module: `burst_col_gen`

## Requirements
- R1: During and right after an active-low synchronous reset, `active_o` and `done_o` are 0 and `col_o` is 0.
- R2: After a clock edge that samples `start_i`=1 with a legal configuration, `active_o` is 1 and `col_o` equals the sampled `start_col_i` (beat 0). Length codes are: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. `burst_type_i`=0 selects sequential ordering and 1 selects interleaved.
- R3: In sequential ordering with burst length BL, beat n has column bits above log2(BL) equal to the start column. Its low log2(BL) bits equal (start low bits + n) mod BL.
- R4: In interleaved ordering, beat n has column bits equal to the start column with the low log2(BL) bits XORed with n.
- R5: A full-page burst (code 7, sequential) shows (start + n) mod 512 on beat n. It never raises `done_o`, and it stays active through any number of advances.
- R6: For a fixed-length burst, `done_o` is 1 exactly while the last beat's column is shown. Advancing that beat makes `active_o` 0 and `col_o` 0 on the next cycle.
- R7: While a burst is active and `advance_i`, `stop_i` and `start_i` are all 0, `col_o` and `active_o` hold.
- R8: `stop_i`=1 during an active burst, with no legal start in the same cycle, makes `active_o` 0 on the next cycle.
- R9: A legal start during an active burst replaces it on the next cycle, even if `stop_i` is also 1.
- R10: `cfg_illegal_o` is 1 for codes 4, 5 and 6, and for code 7 with interleaved ordering. A start under such a configuration is ignored: an idle block stays idle and an active burst continues.
- R11: A burst of length 1 raises `done_o` on the first cycle it is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a new burst with the present configuration |
| start_col_i | input | 9 | Start column of the burst |
| bl_code_i | input | 3 | Burst length code |
| burst_type_i | input | 1 | 0 sequential, 1 interleaved |
| advance_i | input | 1 | Move to the next beat |
| stop_i | input | 1 | End the current burst |
| col_o | output | 9 | Column of the current beat, 0 when idle |
| active_o | output | 1 | A burst is in progress |
| done_o | output | 1 | The current beat is the last of a fixed-length burst |
| cfg_illegal_o | output | 1 | Present length/type combination is not allowed |

## Verification
Every registered result is due one clock edge after the input that causes it: the start column, each advanced column, the drop of the active flag and done on the new beat. Only `cfg_illegal_o` is combinational and follows its inputs in the same cycle. The driver sets inputs at the falling edge and pushes the state a reference model expects after the next rising edge. The monitor pops and compares that entry 1 ns after the rising edge, so each comparison lines up with the single-register latency. The configuration flag is checked directly, a short delay after its inputs change.

// File: rtl/bcg_pkg.sv
// Shared definitions for the burst column sequencer.
// Assumes a 3-bit length code; codes 4..6 are reserved.
package bcg_pkg;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        LEN_1    = 3'd0,
        LEN_2    = 3'd1,
        LEN_4    = 3'd2,
        LEN_8    = 3'd3,
        LEN_PAGE = 3'd7
    } len_code_e;

    // Largest code that selects a fixed power-of-two length
    localparam logic [CODE_W-1:0] LAST_FIXED = LEN_8;
endpackage

// File: rtl/bcg_len_decode.sv
// Turns the length code and ordering bit into a wrap mask, a full-page
// flag and a legality flag. Purely combinational.
// Assumes COL_W is at least log2 of the largest fixed length (8).
module bcg_len_decode
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              ilv_i,
    output logic [COL_W-1:0]  mask_o,
    output logic              full_o,
    output logic              legal_o
);
    logic reserved;

    // Classify the code: full page, reserved or fixed length
    always_comb begin
        full_o   = (code_i == LEN_PAGE);
        reserved = (code_i > LAST_FIXED) && !full_o;
        legal_o  = !reserved && !(full_o && ilv_i);
    end

    // Build the wrap mask: low log2(BL) ones, or all ones for full page
    always_comb begin
        for (int i = 0; i < COL_W; i++) begin
            mask_o[i] = full_o || (i < int'(code_i));
        end
    end
endmodule

// File: rtl/bcg_beat_ctr.sv
// Beat index and burst activity. A launch clears the index and makes
// the burst active. A stop ends it. An advance steps the index, or ends
// the burst when the last beat of a fixed length is shown.
// Assumes mask_i/full_i are the latched configuration of the live burst.
module bcg_beat_ctr #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic             stop_i,
    input  logic             advance_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             full_i,
    output logic [COL_W-1:0] beat_o,
    output logic             active_o,
    output logic             last_o
);
    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic [COL_W-1:0] beat_q;
    logic             active_q;

    // Last beat: every bit under the mask is set, fixed length only
    always_comb last_o = active_q && !full_i && ((beat_q & mask_i) == mask_i);

    // Step the beat index and track whether a burst is live
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            beat_q   <= '0;
        end else if (launch_i) begin
            active_q <= 1'b1;
            beat_q   <= '0;
        end else if (active_q) begin
            if (stop_i) begin
                active_q <= 1'b0;
            end else if (advance_i) begin
                if (last_o) active_q <= 1'b0;
                else        beat_q   <= beat_q + ONE;
            end
        end
    end

    assign beat_o   = beat_q;
    assign active_o = active_q;

    // R6
    last_beat_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && advance_i && !stop_i && !launch_i) |=> !active_o);
    // R8
    stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && stop_i && !launch_i) |=> !active_o);
    // R9
    relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |=> (active_o && beat_o == '0));
endmodule

// File: rtl/bcg_addr_mix.sv
// Forms the column of the current beat from the start column, the wrap
// mask and the beat index, in sequential or interleaved order.
// Assumes beat_i never exceeds the mask for fixed lengths.
module bcg_addr_mix #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    input  logic             active_i,
    input  logic [COL_W-1:0] beat_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] ilv_col;

    // Compute both orderings and pick one, zero while idle
    always_comb begin
        seq_col = (base_i & ~mask_i) | ((base_i + beat_i) & mask_i);
        ilv_col = base_i ^ (beat_i & mask_i);
        if (!active_i)  col_o = '0;
        else if (ilv_i) col_o = ilv_col;
        else            col_o = seq_col;
    end
endmodule

// File: rtl/burst_col_gen.sv
// Burst column sequencer top. It latches the start column and decoded
// configuration on a legal start, then presents one column per beat.
// Assumes a start and a stop may both arrive on any cycle; start wins.
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [CODE_W-1:0] bl_code_i,
    input  logic              burst_type_i,
    input  logic              advance_i,
    input  logic              stop_i,
    output logic [COL_W-1:0]  col_o,
    output logic              active_o,
    output logic              done_o,
    output logic              cfg_illegal_o
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_legal;
    logic             launch;

    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             full_q;
    logic             ilv_q;
    logic [COL_W-1:0] beat;

    bcg_len_decode #(.COL_W(COL_W)) dec_i (
        .code_i  (bl_code_i),
        .ilv_i   (burst_type_i),
        .mask_o  (dec_mask),
        .full_o  (dec_full),
        .legal_o (dec_legal)
    );

    // A start counts only under a legal configuration
    always_comb launch = start_i && dec_legal;

    // Latch the start column and decoded configuration for the burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            full_q <= 1'b0;
            ilv_q  <= 1'b0;
        end else if (launch) begin
            base_q <= start_col_i;
            mask_q <= dec_mask;
            full_q <= dec_full;
            ilv_q  <= burst_type_i;
        end
    end

    bcg_beat_ctr #(.COL_W(COL_W)) ctr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (launch),
        .stop_i    (stop_i),
        .advance_i (advance_i),
        .mask_i    (mask_q),
        .full_i    (full_q),
        .beat_o    (beat),
        .active_o  (active_o),
        .last_o    (done_o)
    );

    bcg_addr_mix #(.COL_W(COL_W)) mix_i (
        .base_i   (base_q),
        .mask_i   (mask_q),
        .ilv_i    (ilv_q),
        .active_i (active_o),
        .beat_i   (beat),
        .col_o    (col_o)
    );

    assign cfg_illegal_o = !dec_legal;

    // R2
    first_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (active_o && col_o == $past(start_col_i)));
    // R5
    page_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && full_q) |-> !done_o);
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !advance_i && !stop_i && !start_i) |=> (active_o && $stable(col_o)));
    // R10
    illegal_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && cfg_illegal_o && !active_o) |=> !active_o);
endmodule

// File: tb/burst_col_gen_tb_top.sv
`timescale 1ns/1ps
module burst_col_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i, burst_type_i, advance_i, stop_i;
    logic [8:0] start_col_i;
    logic [2:0] bl_code_i;
    logic [8:0] col_o;
    logic       active_o, done_o, cfg_illegal_o;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 0;

    typedef struct {
        logic [8:0] col;
        logic       act;
        logic       dn;
        string      tag;
    } exp_t;
    exp_t q[$];

    // Reference state
    bit m_act = 0;
    bit m_full = 0;
    bit m_ilv = 0;
    int m_base = 0;
    int m_len = 1;
    int m_beat = 0;

    always #2.5 clk = ~clk;

    burst_col_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .bl_code_i(bl_code_i), .burst_type_i(burst_type_i), .advance_i(advance_i),
        .stop_i(stop_i), .col_o(col_o), .active_o(active_o), .done_o(done_o),
        .cfg_illegal_o(cfg_illegal_o)
    );

    function automatic bit ref_legal(int code, bit ty);
        if (code >= 4 && code <= 6) return 0;
        if (code == 7 && ty) return 0;
        return 1;
    endfunction

    function automatic int ref_col();
        int off;
        if (!m_act) return 0;
        if (m_full) return (m_base + m_beat) % 512;
        if (m_ilv)  return m_base ^ m_beat;
        off = m_base % m_len;
        return m_base - off + ((off + m_beat) % m_len);
    endfunction

    // Driver: apply one cycle of stimulus and queue the expected result
    task automatic cyc(input bit st, input int sc, input int code, input bit ty,
                       input bit adv, input bit sp, input string tag);
        exp_t e;
        @(negedge clk);
        start_i = st; start_col_i = 9'(sc); bl_code_i = 3'(code);
        burst_type_i = ty; advance_i = adv; stop_i = sp;
        if (st && ref_legal(code, ty)) begin
            m_act = 1; m_beat = 0; m_base = sc; m_ilv = ty;
            m_full = (code == 7); m_len = m_full ? 512 : (1 << code);
        end else if (m_act) begin
            if (sp) m_act = 0;
            else if (adv) begin
                if (!m_full && m_beat == m_len - 1) m_act = 0;
                else m_beat = (m_beat + 1) % 512;
            end
        end
        e.col = 9'(ref_col());
        e.act = m_act;
        e.dn  = m_act && !m_full && (m_beat == m_len - 1);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic check_cfg(input int code, input bit ty, input bit exp_bad);
        @(negedge clk);
        start_i = 0; advance_i = 0; stop_i = 0;
        bl_code_i = 3'(code); burst_type_i = ty;
        #0.5;
        n_cmp++;
        if (cfg_illegal_o !== exp_bad) begin
            n_bad++;
            $display("FAIL R10 cfg code=%0d type=%0d: got %0b expected %0b",
                     code, ty, cfg_illegal_o, exp_bad);
        end
    endtask

    // Monitor: compare the design's outputs just after each rising edge
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            n_cmp++;
            if (col_o !== e.col || active_o !== e.act || done_o !== e.dn) begin
                n_bad++;
                $display("FAIL %s: got col=%h act=%0b done=%0b expected col=%h act=%0b done=%0b",
                         e.tag, col_o, active_o, done_o, e.col, e.act, e.dn);
            end
        end
    end

    initial begin
        rst_n = 0; start_i = 0; start_col_i = 0; bl_code_i = 0;
        burst_type_i = 0; advance_i = 0; stop_i = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (col_o !== 0 || active_o !== 0 || done_o !== 0) begin
            n_bad++;
            $display("FAIL R1 reset: got col=%h act=%0b done=%0b expected 0 0 0",
                     col_o, active_o, done_o);
        end
        rst_n = 1;
        idle(2, "R1 idle after reset");

        // R2 R3 R6: sequential length 8 from 0x1F5, wraps within 0x1F0..0x1F7
        cyc(1, 'h1F5, 3, 0, 0, 0, "R2 seq8 first column");
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 1, 0, "R3 R6 seq8 beat");
        // R7: hold with no advance, then continue
        cyc(1, 'h033, 2, 0, 0, 0, "R2 seq4 start");
        idle(3, "R7 hold without advance");
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 0, "R3 R6 seq4 beat");

        // R4: interleaved length 4 and length 8
        cyc(1, 'h0A2, 2, 1, 0, 0, "R4 ilv4 start");
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 0, "R4 ilv4 beat");
        cyc(1, 'h113, 3, 1, 1, 0, "R4 ilv8 start");
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 1, 0, "R4 ilv8 beat");

        // R5 R8: full page across the page end, then stop
        cyc(1, 'h1FC, 7, 0, 0, 0, "R5 page start");
        for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 1, 0, "R5 page wrap");
        cyc(0, 0, 0, 0, 1, 1, "R8 stop page burst");
        idle(1, "R8 idle after stop");

        // R11: length 1
        cyc(1, 'h044, 0, 0, 0, 0, "R11 len1 done at once");
        cyc(0, 0, 0, 0, 1, 0, "R6 R11 len1 ends");

        // R9: restart mid burst with stop in the same cycle
        cyc(1, 'h016, 1, 0, 0, 0, "R2 seq2 start");
        cyc(1, 'h0C9, 3, 1, 0, 1, "R9 restart beats stop");
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 1, 0, "R9 R4 replaced burst");

        // R8: stop in middle of sequential length 4
        cyc(1, 'h07E, 2, 0, 0, 0, "R2 seq4 start");
        cyc(0, 0, 0, 0, 1, 0, "R3 seq4 beat");
        cyc(0, 0, 0, 0, 0, 1, "R8 stop mid burst");

        // R10: illegal configurations ignored
        cyc(1, 'h100, 7, 1, 0, 0, "R10 ilv page ignored idle");
        cyc(1, 'h101, 5, 0, 0, 0, "R10 reserved code ignored idle");
        cyc(1, 'h0F0, 3, 0, 0, 0, "R2 seq8 start");
        cyc(1, 'h055, 6, 0, 1, 0, "R10 reserved start during burst");
        cyc(1, 'h055, 7, 1, 1, 0, "R10 ilv page start during burst");
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1, 0, "R10 burst continues");
        idle(2, "R6 idle after end");

        check_cfg(7, 1, 1);
        check_cfg(4, 0, 1);
        check_cfg(6, 1, 1);
        check_cfg(7, 0, 0);
        check_cfg(3, 1, 0);
        check_cfg(0, 0, 0);

        repeat (3) @(posedge clk);
        #2;
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule